// File: doc/BRIEF.md
# Byte Transceiver Register Block

This block is the register face of a simple byte-wide network port. A processor reaches it through a byte-wide memory bus. Three addresses in that bus are mapped to the block: a status register, an outgoing data register and an incoming data register. On the line side, the block hands one outgoing byte at a time to a serializer through a valid/ready pair. It also takes incoming bytes from a receiver that offers a byte for one cycle with a valid strobe.

Ownership of the status bits is split between the processor and the device. Software loads a byte and then sets the busy bit; the device clears that bit when the serializer takes the byte. The device sets the full bit when a byte lands in the incoming register; software clears it once it has read the byte. A second byte that arrives before the first is acknowledged overwrites it and raises a sticky overrun bit. Two level interrupt outputs tell the processor that a byte has gone out or that one has arrived.

Top module: `xcvr_regs`

## Requirements
- R1: After reset the status register reads 0, the incoming data register reads 0, and `tx_valid`, `irq_tx` and `irq_rx` are low.
- R2: A bus write to the outgoing data address (default 98) while status bit 0 is 0 loads the byte. From the next cycle it is shown on `tx_data` and returned by a read of that address.
- R3: A bus write to the outgoing data address while status bit 0 is 1 has no effect: `tx_data` and the read-back value keep the byte loaded before.
- R4: A status write (default address 97) with data bit 0 = 1 while bit 0 is 0 sets bit 0 and raises `tx_valid` from the next cycle. A status write with data bit 0 = 0 never clears bit 0.
- R5: A clock edge with `tx_valid` and `tx_ready` both high completes the transfer. After it, status bit 0 is 0 and `tx_valid` is low. While `tx_ready` stays low, `tx_valid` stays high.
- R6: A clock edge with `rx_valid` high stores `rx_data` in the incoming register, which a read of the incoming address (default 99) returns. The same edge sets status bit 1 and raises `irq_rx`.
- R7: A status write with data bit 1 = 0 clears status bit 1 and `irq_rx`. A status write with data bit 1 = 1 leaves bit 1 unchanged and can never set it.
- R8: A byte that arrives while status bit 1 is 1 replaces the stored byte and sets status bit 2. Bit 2 stays set until any status write, which clears it; an arrival in the same cycle as that write wins.
- R9: A completed transfer raises `irq_tx`. It stays high through idle cycles until a status write clears it.
- R10: Status bits 7 to 3 always read 0. A read of any unmapped address returns 0, and `bus_rdata` is 0 whenever `bus_rd` is low.
- R11: If a byte arrives in the same cycle as a status write that clears bit 1, the arrival wins: bit 1 stays 1 and the new byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Bus byte address |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rd | input | 1 | Bus read enable |
| bus_rdata | output | 8 | Bus read data, combinational from address |
| tx_valid | output | 1 | Outgoing byte offered to serializer |
| tx_ready | input | 1 | Serializer accepts the offered byte |
| tx_data | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_data | input | 8 | Incoming byte |
| irq_tx | output | 1 | Transfer-complete interrupt, level |
| irq_rx | output | 1 | Byte-arrived interrupt, level |

## Verification
The hardest case to reach is a collision between the two owners of a status bit in one cycle. The main example is a byte arriving on the very edge where software clears the full bit, while the overrun bit is also being cleared. The bench reaches it by filling the incoming register first. It then drives `rx_valid` and a status write of zero on the same falling edge, so both land on one rising edge. After that it reads back the exact arithmetic value of the status register. A sweep over all 256 status write values shows that software can set only bit 0 and that no other bit can be set from the bus.

// File: rtl/xcvr_pkg.sv
// Package: shared definitions for the byte transceiver register block.
// Assumes: status bit positions are fixed and decoded by software.
package xcvr_pkg;
    localparam int ST_TX_BUSY = 0;
    localparam int ST_RX_FULL = 1;
    localparam int ST_RX_OVR  = 2;
    localparam int ST_USED    = 3;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_TXD  = 2'd2,
        SEL_RXD  = 2'd3
    } rsel_e;
endpackage

// File: rtl/xcvr_decode.sv
// Module: address decoder. Turns bus address and strobes into per-register
// write strobes and a read select.
// Assumes: the three addresses are distinct and fit in ADDR_W bits.
module xcvr_decode #(
    parameter int ADDR_W    = 8,
    parameter int STAT_ADDR = 97,
    parameter int TXD_ADDR  = 98,
    parameter int RXD_ADDR  = 99
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              wr_stat,
    output logic              wr_txd,
    output xcvr_pkg::rsel_e   rsel
);
    import xcvr_pkg::*;

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(TXD_ADDR);
    localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(RXD_ADDR);

    // Write strobes: one per writable register.
    always_comb begin
        wr_stat = bus_wr && (bus_addr == A_STAT);
        wr_txd  = bus_wr && (bus_addr == A_TXD);
    end

    // Read select: which register drives read data, none when not reading.
    always_comb begin
        rsel = SEL_NONE;
        if (bus_rd) begin
            if (bus_addr == A_STAT)     rsel = SEL_STAT;
            else if (bus_addr == A_TXD) rsel = SEL_TXD;
            else if (bus_addr == A_RXD) rsel = SEL_RXD;
        end
    end
endmodule

// File: rtl/xcvr_tx_path.sv
// Module: outgoing side. Holds the outgoing byte and the busy bit, drives the
// valid/ready handshake and the transfer-complete interrupt.
// Assumes: start and load requests arrive as one-cycle strobes from the decoder.
module xcvr_tx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic              wr_txd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              busy,
    output logic              irq_tx
);
    import xcvr_pkg::*;

    logic              busy_q;
    logic [DATA_W-1:0] data_q;
    logic              irq_q;
    logic              start;
    logic              done;

    // Event decode: software start request and handshake completion.
    always_comb begin
        start = wr_stat && wdata[ST_TX_BUSY] && !busy_q;
        done  = busy_q && tx_ready;
    end

    // Busy bit: set only by software, cleared only by the device.
    always_ff @(posedge clk) begin
        if (!rst_n)     busy_q <= 1'b0;
        else if (start) busy_q <= 1'b1;
        else if (done)  busy_q <= 1'b0;
    end

    // Outgoing byte: loads only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 data_q <= '0;
        else if (wr_txd && !busy_q) data_q <= wdata;
    end

    // Completion interrupt: set on done, cleared by any status write, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (done)    irq_q <= 1'b1;
        else if (wr_stat) irq_q <= 1'b0;
    end

    assign tx_valid = busy_q;
    assign tx_data  = data_q;
    assign busy     = busy_q;
    assign irq_tx   = irq_q;

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid); // R5
    AST_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!tx_valid && irq_tx)); // R5
    AST_TXD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(tx_data)); // R3
    AST_IRQ_TX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tx && !wr_stat) |=> irq_tx); // R9
endmodule

// File: rtl/xcvr_rx_path.sv
// Module: incoming side. Captures each strobed byte and keeps the full,
// overrun and arrival-interrupt flags.
// Assumes: the receiver never stalls; a byte is taken on every strobe.
module xcvr_rx_path #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              wr_stat,
    input  logic              keep_full,
    output logic [DATA_W-1:0] rx_byte,
    output logic              full,
    output logic              ovr,
    output logic              irq_rx
);
    logic [DATA_W-1:0] byte_q;
    logic              full_q;
    logic              ovr_q;
    logic              irq_q;
    logic              ack;

    // Software acknowledge: a status write with the full bit written as zero.
    always_comb ack = wr_stat && !keep_full;

    // Incoming byte: always the last byte taken from the line.
    always_ff @(posedge clk) begin
        if (!rst_n)        byte_q <= '0;
        else if (rx_valid) byte_q <= rx_data;
    end

    // Full bit: set by the device, cleared by software, arrival wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        full_q <= 1'b0;
        else if (rx_valid) full_q <= 1'b1;
        else if (ack)      full_q <= 1'b0;
    end

    // Overrun bit: sticky, cleared by any status write, arrival wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovr_q <= 1'b0;
        else if (rx_valid && full_q) ovr_q <= 1'b1;
        else if (wr_stat)            ovr_q <= 1'b0;
    end

    // Arrival interrupt: raised on capture, dropped on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_q <= 1'b0;
        else if (rx_valid) irq_q <= 1'b1;
        else if (ack)      irq_q <= 1'b0;
    end

    assign rx_byte = byte_q;
    assign full    = full_q;
    assign ovr     = ovr_q;
    assign irq_rx  = irq_q;

    AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (full && irq_rx && rx_byte == $past(rx_data))); // R6
    AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && full) |=> ovr); // R8
    AST_RX_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !full) |=> !full); // R7
    AST_RX_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !rx_valid) |=> (!full && !irq_rx)); // R7
endmodule

// File: rtl/xcvr_regs.sv
// Module: top of the byte transceiver register block. Connects the decoder,
// the outgoing and incoming paths, and muxes bus read data.
// Assumes: DATA_W >= 3 so that the three status bits fit; reads are free of
// side effects and read data is combinational from the address.
module xcvr_regs #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int STAT_ADDR = 97,
    parameter int TXD_ADDR  = 98,
    parameter int RXD_ADDR  = 99
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              irq_tx,
    output logic              irq_rx
);
    import xcvr_pkg::*;

    localparam int PAD_W = DATA_W - ST_USED;

    logic              wr_stat;
    logic              wr_txd;
    rsel_e             rsel;
    logic              busy;
    logic              full;
    logic              ovr;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] status;

    xcvr_decode #(
        .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
        .TXD_ADDR(TXD_ADDR), .RXD_ADDR(RXD_ADDR)
    ) u_dec (
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .wr_stat(wr_stat), .wr_txd(wr_txd), .rsel(rsel)
    );

    xcvr_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wr_txd(wr_txd),
        .wdata(bus_wdata), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .busy(busy), .irq_tx(irq_tx)
    );

    xcvr_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .wr_stat(wr_stat), .keep_full(bus_wdata[ST_RX_FULL]),
        .rx_byte(rx_byte), .full(full), .ovr(ovr), .irq_rx(irq_rx)
    );

    // Status word: three live bits, upper bits tied to zero.
    always_comb status = {{PAD_W{1'b0}}, ovr, full, busy};

    // Read mux: selected register or zero.
    always_comb begin
        case (rsel)
            SEL_STAT: bus_rdata = status;
            SEL_TXD:  bus_rdata = tx_data;
            SEL_RXD:  bus_rdata = rx_byte;
            default:  bus_rdata = '0;
        endcase
    end

    // Read-data guard: upper status bits and idle bus read as zero.
    always_comb begin
        if (rst_n && rsel == SEL_STAT)
            AST_STAT_UPPER_ZERO: assert (bus_rdata[DATA_W-1:ST_USED] == '0); // R10
        if (rst_n && !bus_rd)
            AST_IDLE_READ_ZERO: assert (bus_rdata == '0); // R10
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !irq_tx && !irq_rx)); // R1
endmodule

// File: tb/sim_xcvr_regs.sv
module sim_xcvr_regs;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_ST = 8'd97;
    localparam logic [7:0] A_TX = 8'd98;
    localparam logic [7:0] A_RX = 8'd99;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       irq_tx;
    logic       irq_rx;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic rx_byte(input logic [7:0] d);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic tx_accept();
        @(negedge clk);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus_read(A_ST, r); check("R1 status", r, 0);
        bus_read(A_RX, r); check("R1 rx reg", r, 0);
        check("R1 tx_valid", tx_valid, 0);
        check("R1 irq_tx", irq_tx, 0);
        check("R1 irq_rx", irq_rx, 0);

        // R10: unmapped address and idle bus read zero
        bus_read(8'd96, r); check("R10 unmapped", r, 0);
        bus_read(8'd100, r); check("R10 unmapped", r, 0);
        bus_addr = A_TX; #1; check("R10 no-read zero", bus_rdata, 0);

        // Outgoing sweep over a spread of bytes
        for (int i = 0; i < 16; i++) begin
            logic [7:0] b;
            b = 8'(i * 17 + 3);
            bus_write(A_TX, b);
            bus_read(A_TX, r); check("R2 readback", r, b);
            check("R2 tx_data", tx_data, b);
            bus_write(A_ST, 8'h01);
            check("R4 tx_valid up", tx_valid, 1);
            bus_read(A_ST, r); check("R4 busy bit", r, 1);
            bus_write(A_TX, ~b);
            bus_read(A_TX, r); check("R3 write ignored", r, b);
            check("R3 tx_data held", tx_data, b);
            bus_write(A_ST, 8'h00);
            check("R4 zero no clear", tx_valid, 1);
            repeat (i % 4) @(negedge clk);
            check("R5 hold while not ready", tx_valid, 1);
            tx_accept();
            check("R5 tx_valid down", tx_valid, 0);
            bus_read(A_ST, r); check("R5 busy cleared", r, 0);
            check("R9 irq_tx set", irq_tx, 1);
            repeat (3) @(negedge clk);
            check("R9 irq_tx held", irq_tx, 1);
            bus_write(A_ST, 8'h00);
            check("R9 irq_tx cleared", irq_tx, 0);
        end

        // Incoming sweep
        for (int i = 0; i < 16; i++) begin
            logic [7:0] b;
            b = 8'(255 - i * 13);
            rx_byte(b);
            bus_read(A_RX, r); check("R6 rx byte", r, b);
            bus_read(A_ST, r); check("R6 full bit", r, 2);
            check("R6 irq_rx", irq_rx, 1);
            bus_write(A_ST, 8'h02);
            bus_read(A_ST, r); check("R7 write one keeps", r, 2);
            bus_write(A_ST, 8'h00);
            bus_read(A_ST, r); check("R7 cleared", r, 0);
            check("R7 irq_rx low", irq_rx, 0);
        end

        // R8: overrun
        rx_byte(8'h5A);
        rx_byte(8'hC3);
        bus_read(A_RX, r); check("R8 overwrite", r, 8'hC3);
        bus_read(A_ST, r); check("R8 overrun set", r, 6);
        bus_write(A_ST, 8'h02);
        bus_read(A_ST, r); check("R8 overrun cleared", r, 2);

        // R11 and R8: arrival on the same edge as a clearing status write
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h77;
        bus_addr = A_ST; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; bus_wr = 1'b0;
        bus_read(A_ST, r); check("R11 arrival wins", r, 6);
        bus_read(A_RX, r); check("R11 new byte", r, 8'h77);
        check("R11 irq_rx", irq_rx, 1);
        bus_write(A_ST, 8'h00);
        bus_read(A_ST, r); check("R7 final clear", r, 0);

        // R9: completion on the same edge as a status write keeps irq_tx
        bus_write(A_ST, 8'h01);
        @(negedge clk);
        tx_ready = 1'b1; bus_addr = A_ST; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0; bus_wr = 1'b0;
        check("R9 set wins", irq_tx, 1);
        bus_write(A_ST, 8'h00);
        check("R9 cleared after", irq_tx, 0);

        // Exhaustive status write sweep: only bit 0 can be set
        for (int v = 0; v < 256; v++) begin
            bus_write(A_ST, 8'(v));
            bus_read(A_ST, r);
            check("R10 status sweep", r, v & 1);
            if ((v & 1) != 0) begin
                tx_accept();
                bus_write(A_ST, 8'h00);
            end
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule